// File: doc/BRIEF.md
# Pixel Colour Gain/Offset Processor

This block is a pipelined colour adjuster for 8-bit RGB video. It accepts one pixel per clock, marked by a valid flag, and returns the adjusted pixel a fixed number of cycles later with the flag delayed to match. The adjustment happens in two colour spaces. First, each RGB component is scaled by its own gain and shifted by its own offset. The pixel is then converted into a luma term and two colour-difference terms, one blue and one red. A luma gain sets contrast and a luma offset sets brightness. A gain and an offset on each colour-difference term set saturation. Because the luma settings move all three components by the same amount, they leave colour temperature unchanged. The result is converted back to RGB and saturated to 0..255.

The forward transform computes luma in quarter units as `Y4 = R + 2G + B`, with `Cb4 = 4B - Y4` and `Cr4 = 4R - Y4`. This transform inverts exactly in integers, so neutral settings return the input unchanged. Twelve 8-bit registers hold the settings and are written through a plain address/data write port. There is no handshake and no shadowing: a write takes effect on the next clock edge for every stage that reads it.

Top module: `pix_tone_adjust`

## Requirements
- R1: Register map (address: content): 0 red gain, 1 red offset, 2 green gain, 3 green offset, 4 blue gain, 5 blue offset, 6 luma gain, 7 luma offset, 8 blue-difference gain, 9 blue-difference offset, 10 red-difference gain, 11 red-difference offset. After reset every gain holds 80h and every offset holds 00h. A write is accepted when `cfg_we` is high at a clock edge. A write to addresses 12 to 15 changes nothing.
- R2: Each component is first computed as `c1 = sat(((c*gain + 64) >> 7) + offs)`. The gain is unsigned, with 80h meaning 1.0. The offset is two's complement, from -128 to +127. `sat` limits the result to 0..255.
- R3: From the stage-one values, `Y4 = R1 + 2*G1 + B1`, `Cb4 = 4*B1 - Y4` and `Cr4 = 4*R1 - Y4`. A grey pixel (R = G = B) therefore carries zero colour difference, and chroma gains do not affect it.
- R4: The adjusted luma is `Ya = floor((Y4*ygain + 64)/128) + 4*yoffs`. The offset counts in whole output steps.
- R5: Each adjusted colour difference is `Ca = floor((C4*cgain + 64)/128) + 4*coffs`, scaled about zero chroma, with a signed floor.
- R6: The output is `R4 = Ya + Cra`, `B4 = Ya + Cba` and `G4 = Ya - floor((Cba + Cra)/2)`. Each component is then `floor((X4 + 2)/4)`. Zero colour difference yields R = G = B.
- R7: Every output component saturates to the range 0 to 255, at both ends.
- R8: A pixel sampled with `in_valid` high appears 4 clock edges later with `out_valid` high. `out_valid` is low after reset and is high exactly once for each input pixel.
- R9: With all gains at 80h and all offsets at 00h, the output equals the input exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
The hardest cases to reach from the ports are those where an intermediate term leaves the pixel range. A strongly saturated colour difference can push one output component past 255 while another drops below zero. A negative colour difference, after odd halving, exercises the floor rounding of the green path. The bench reaches these by sweeping a coarse cube of pixels under settings with extreme gains and offsets on each of the two colour spaces. It also runs random pixels with every setting away from neutral. A grey ramp under maximum chroma gain checks that colour differences are zero. Writes to the four unused addresses, followed by a neutral sweep, check that they alias nothing.

// File: rtl/pix_tone_pkg.sv
package pix_tone_pkg;
    localparam int CW     = 8;
    localparam int NREG   = 12;
    localparam int CFG_AW = 4;
    localparam int LAT    = 4;

    typedef enum logic [CFG_AW-1:0] {
        RA_R_GAIN  = 4'd0,  RA_R_OFFS  = 4'd1,
        RA_G_GAIN  = 4'd2,  RA_G_OFFS  = 4'd3,
        RA_B_GAIN  = 4'd4,  RA_B_OFFS  = 4'd5,
        RA_Y_GAIN  = 4'd6,  RA_Y_OFFS  = 4'd7,
        RA_CB_GAIN = 4'd8,  RA_CB_OFFS = 4'd9,
        RA_CR_GAIN = 4'd10, RA_CR_OFFS = 4'd11
    } tone_reg_e;

    typedef struct packed {
        logic [2:0][CW-1:0] ch_gain;
        logic [2:0][CW-1:0] ch_offs;
        logic [CW-1:0]      y_gain;
        logic [CW-1:0]      y_offs;
        logic [CW-1:0]      cb_gain;
        logic [CW-1:0]      cb_offs;
        logic [CW-1:0]      cr_gain;
        logic [CW-1:0]      cr_offs;
    } tone_cfg_t;
endpackage

// File: rtl/pix_tone_cfg.sv
module pix_tone_cfg
    import pix_tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output tone_cfg_t         cfg
);
    localparam logic [CW-1:0] UNITY = CW'(1 << (CW - 1));

    logic [CW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs[i] <= (i % 2 == 0) ? UNITY : '0;
        end else if (we && int'(addr) < NREG) begin
            regs[addr] <= wdata;
        end
    end

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            cfg.ch_gain[k] = regs[2*k];
            cfg.ch_offs[k] = regs[2*k+1];
        end
        cfg.y_gain  = regs[int'(RA_Y_GAIN)];
        cfg.y_offs  = regs[int'(RA_Y_OFFS)];
        cfg.cb_gain = regs[int'(RA_CB_GAIN)];
        cfg.cb_offs = regs[int'(RA_CB_OFFS)];
        cfg.cr_gain = regs[int'(RA_CR_GAIN)];
        cfg.cr_offs = regs[int'(RA_CR_OFFS)];
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) < NREG) |=> regs[$past(addr)] == $past(wdata)); // R1
endmodule

// File: rtl/pix_tone_chan.sv
module pix_tone_chan
    import pix_tone_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [CW-1:0]    gain,
    input  logic [CW-1:0]    offs,
    output logic [PIX_W-1:0] pix_o
);
    localparam int PW   = PIX_W + CW;
    localparam int SW   = PIX_W + 2;
    localparam int TW   = SW + 2;
    localparam int HALF = 1 << (CW - 2);
    localparam int MAXV = (1 << PIX_W) - 1;
    localparam logic [CW-1:0] UNITY = CW'(1 << (CW - 1));

    logic [PW-1:0]        prod;
    logic [PW:0]          rnd;
    logic [SW-1:0]        scaled;
    logic signed [TW-1:0] sum;

    always_comb begin
        prod   = PW'(pix_i) * PW'(gain);
        rnd    = {1'b0, prod} + (PW+1)'(HALF);
        scaled = rnd[PW:CW-1];
        sum    = $signed({2'b00, scaled}) + $signed({{(TW-CW){offs[CW-1]}}, offs});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pix_o <= '0;
        else if (sum < 0)       pix_o <= '0;
        else if (sum > MAXV)    pix_o <= PIX_W'(MAXV);
        else                    pix_o <= sum[PIX_W-1:0];
    end

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == UNITY && offs == '0) |=> pix_o == $past(pix_i)); // R9
endmodule

// File: rtl/pix_tone_luma.sv
module pix_tone_luma
    import pix_tone_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int AW   = PIX_W + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIX_W-1:0]     r_i,
    input  logic [PIX_W-1:0]     g_i,
    input  logic [PIX_W-1:0]     b_i,
    input  logic [CW-1:0]        y_gain,
    input  logic [CW-1:0]        y_offs,
    input  logic [CW-1:0]        cb_gain,
    input  logic [CW-1:0]        cb_offs,
    input  logic [CW-1:0]        cr_gain,
    input  logic [CW-1:0]        cr_offs,
    output logic signed [AW-1:0] y_o,
    output logic signed [AW-1:0] cb_o,
    output logic signed [AW-1:0] cr_o
);
    localparam int YW   = PIX_W + 2;
    localparam int DW   = PIX_W + 3;
    localparam int HALF = 1 << (CW - 2);

    function automatic logic signed [AW-1:0] offq(input logic [CW-1:0] o);
        return $signed({{(AW-CW-2){o[CW-1]}}, o, 2'b00});
    endfunction

    function automatic logic signed [AW-1:0] cscale(input logic signed [DW-1:0] c,
                                                   input logic [CW-1:0] g,
                                                   input logic [CW-1:0] o);
        logic signed [DW+CW:0] p;
        p = c * $signed({1'b0, g});
        p = p + $signed((DW+CW+1)'(HALF));
        return $signed(p[CW-1 +: AW]) + offq(o);
    endfunction

    logic [YW-1:0]        ysum;
    logic [YW-1:0]        y4;
    logic signed [DW-1:0] cb4, cr4;
    logic [YW+CW-1:0]     yprod;
    logic [YW+CW:0]       yrnd;

    always_comb begin
        ysum  = YW'(r_i) + YW'({g_i, 1'b0}) + YW'(b_i);
        yprod = (YW+CW)'(y4) * (YW+CW)'(y_gain);
        yrnd  = {1'b0, yprod} + (YW+CW+1)'(HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y4  <= '0;
            cb4 <= '0;
            cr4 <= '0;
            y_o <= '0;
            cb_o <= '0;
            cr_o <= '0;
        end else begin
            y4   <= ysum;
            cb4  <= $signed({1'b0, b_i, 2'b00}) - $signed({1'b0, ysum});
            cr4  <= $signed({1'b0, r_i, 2'b00}) - $signed({1'b0, ysum});
            y_o  <= $signed({1'b0, yrnd[YW+CW:CW-1]}) + offq(y_offs);
            cb_o <= cscale(cb4, cb_gain, cb_offs);
            cr_o <= cscale(cr4, cr_gain, cr_offs);
        end
    end

    AST_GREY_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
        (r_i == g_i && g_i == b_i) |=> (cb4 == 0 && cr4 == 0)); // R3
endmodule

// File: rtl/pix_tone_rgb.sv
module pix_tone_rgb #(
    parameter int PIX_W = 8,
    localparam int AW   = PIX_W + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] y_i,
    input  logic signed [AW-1:0] cb_i,
    input  logic signed [AW-1:0] cr_i,
    output logic [PIX_W-1:0]     r_o,
    output logic [PIX_W-1:0]     g_o,
    output logic [PIX_W-1:0]     b_o
);
    localparam int RW   = AW + 1;
    localparam int MAXV = (1 << PIX_W) - 1;

    function automatic logic [PIX_W-1:0] to_pix(input logic signed [RW-1:0] x);
        logic signed [RW-1:0] t;
        t = (x + $signed(RW'(2))) >>> 2;
        if (t < 0)         return '0;
        else if (t > MAXV) return PIX_W'(MAXV);
        else               return t[PIX_W-1:0];
    endfunction

    logic signed [RW-1:0] ye, cbe, cre, r4, g4, b4, csum;

    always_comb begin
        ye   = RW'(y_i);
        cbe  = RW'(cb_i);
        cre  = RW'(cr_i);
        csum = cbe + cre;
        r4   = ye + cre;
        b4   = ye + cbe;
        g4   = ye - (csum >>> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_o <= '0;
            g_o <= '0;
            b_o <= '0;
        end else begin
            r_o <= to_pix(r4);
            g_o <= to_pix(g4);
            b_o <= to_pix(b4);
        end
    end

    AST_NEUTRAL_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_i == 0 && cr_i == 0) |=> (r_o == g_o && g_o == b_o)); // R6
endmodule

// File: rtl/pix_tone_adjust.sv
module pix_tone_adjust
    import pix_tone_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CW-1:0]     cfg_wdata,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int AW = PIX_W + 5;

    tone_cfg_t            cfg;
    logic [PIX_W-1:0]     pix_in [3];
    logic [PIX_W-1:0]     pix_s1 [3];
    logic signed [AW-1:0] y_s3, cb_s3, cr_s3;
    logic [LAT-1:0]       vld_pipe;

    assign pix_in[0] = in_r;
    assign pix_in[1] = in_g;
    assign pix_in[2] = in_b;

    pix_tone_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    for (genvar k = 0; k < 3; k++) begin : g_chan
        pix_tone_chan #(.PIX_W(PIX_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .pix_i (pix_in[k]),
            .gain  (cfg.ch_gain[k]),
            .offs  (cfg.ch_offs[k]),
            .pix_o (pix_s1[k])
        );
    end

    pix_tone_luma #(.PIX_W(PIX_W)) u_luma (
        .clk     (clk),
        .rst_n   (rst_n),
        .r_i     (pix_s1[0]),
        .g_i     (pix_s1[1]),
        .b_i     (pix_s1[2]),
        .y_gain  (cfg.y_gain),
        .y_offs  (cfg.y_offs),
        .cb_gain (cfg.cb_gain),
        .cb_offs (cfg.cb_offs),
        .cr_gain (cfg.cr_gain),
        .cr_offs (cfg.cr_offs),
        .y_o     (y_s3),
        .cb_o    (cb_s3),
        .cr_o    (cr_s3)
    );

    pix_tone_rgb #(.PIX_W(PIX_W)) u_rgb (
        .clk   (clk),
        .rst_n (rst_n),
        .y_i   (y_s3),
        .cb_i  (cb_s3),
        .cr_i  (cr_s3),
        .r_o   (out_r),
        .g_o   (out_g),
        .b_o   (out_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
    end

    assign out_valid = vld_pipe[LAT-1];
endmodule

// File: tb/sim_pix_tone_adjust.sv
`timescale 1ns/1ps
module sim_pix_tone_adjust;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_r, out_g, out_b;

    int    checks = 0;
    int    errors = 0;
    int    cfg_sh [12];
    int    exp_q [$];
    string cur_req = "R9";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    pix_tone_adjust u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_r(in_r), .in_g(in_g),
        .in_b(in_b), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int sx(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int outc(int x4);
        return clampi((x4 + 2) >>> 2, 0, 255);
    endfunction

    // Reference model built from R2..R6
    function automatic int model(int r, int g, int b);
        int r1, g1, b1, y4, cb4, cr4, ya, cba, cra;
        r1  = clampi(((r * cfg_sh[0] + 64) >>> 7) + sx(cfg_sh[1]), 0, 255);
        g1  = clampi(((g * cfg_sh[2] + 64) >>> 7) + sx(cfg_sh[3]), 0, 255);
        b1  = clampi(((b * cfg_sh[4] + 64) >>> 7) + sx(cfg_sh[5]), 0, 255);
        y4  = r1 + 2 * g1 + b1;
        cb4 = 4 * b1 - y4;
        cr4 = 4 * r1 - y4;
        ya  = ((y4 * cfg_sh[6] + 64) >>> 7) + 4 * sx(cfg_sh[7]);
        cba = ((cb4 * cfg_sh[8] + 64) >>> 7) + 4 * sx(cfg_sh[9]);
        cra = ((cr4 * cfg_sh[10] + 64) >>> 7) + 4 * sx(cfg_sh[11]);
        return (outc(ya + cra) << 16) | (outc(ya - ((cba + cra) >>> 1)) << 8) | outc(ya + cba);
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 12) cfg_sh[a] = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_cfg(int v [12]);
        idle(8);
        for (int i = 0; i < 12; i++) wr(i, v[i]);
    endtask

    task automatic send(int r, int g, int b);
        @(negedge clk);
        in_valid = 1'b1; in_r = r[7:0]; in_g = g[7:0]; in_b = b[7:0];
        exp_q.push_back(model(r, g, b));
    endtask

    task automatic cube(int step);
        for (int r = 0; r < 256; r += step)
            for (int g = 0; g < 256; g += step)
                for (int b = 0; b < 256; b += step)
                    send(r, g, b);
        idle(8);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Output monitor: every valid output is compared with the model queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) check("R8 unexpected output", 1, 0);
            else check(cur_req, int'({out_r, out_g, out_b}), exp_q.pop_front());
        end
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            report();
        end
    end

    initial begin
        int neutral [12];
        for (int i = 0; i < 12; i++) begin
            cfg_sh[i]  = (i % 2 == 0) ? 128 : 0;
            neutral[i] = cfg_sh[i];
        end
        repeat (4) @(negedge clk);
        check("R8 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", int'(out_valid), 0);

        // R1 reset values and R9 exact identity, with gaps in the stream (R8)
        cur_req = "R9 identity";
        for (int r = 0; r < 256; r += 17)
            for (int g = 0; g < 256; g += 17)
                for (int b = 0; b < 256; b += 17) begin
                    send(r, g, b);
                    if ((r + g + b) % 5 == 0) idle(1);
                end
        idle(8);

        // R8 latency of exactly 4 edges for one isolated pixel
        cur_req = "R8 single";
        send(10, 20, 30);
        @(negedge clk); in_valid = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            if (k > 1) @(negedge clk);
            check("R8 latency", int'(out_valid), (k == 4) ? 1 : 0);
        end
        idle(4);

        // R1: writes to unused addresses 12..15 alias nothing
        for (int a = 12; a < 16; a++) wr(a, 0);
        cur_req = "R1 unused addr";
        cube(51);

        // R2: per-component gain and offset
        cur_req = "R2 rgb stage";
        set_cfg('{200, 10, 64, 236, 128, 0, 128, 0, 128, 0, 128, 0});
        cube(51);
        set_cfg('{255, 127, 255, 128, 0, 50, 128, 0, 128, 0, 128, 0});
        cube(51);

        // R4: contrast and brightness
        cur_req = "R4 luma";
        set_cfg('{128, 0, 128, 0, 128, 0, 96, 226, 128, 0, 128, 0});
        cube(51);
        set_cfg('{128, 0, 128, 0, 128, 0, 255, 127, 128, 0, 128, 0});
        cube(51);

        // R5: saturation, desaturate then skew
        cur_req = "R5 chroma";
        set_cfg('{128, 0, 128, 0, 128, 0, 128, 0, 0, 0, 0, 0});
        cube(51);
        set_cfg('{128, 0, 128, 0, 128, 0, 128, 0, 200, 20, 64, 216});
        cube(51);

        // R3: grey ramp under maximum chroma gain carries no colour difference
        cur_req = "R3 grey";
        set_cfg('{128, 0, 128, 0, 128, 0, 100, 0, 255, 0, 255, 0});
        for (int v = 0; v < 256; v++) send(v, v, v);
        idle(8);

        // R7: saturation at both ends
        cur_req = "R7 sat high";
        set_cfg('{255, 127, 255, 127, 255, 127, 255, 127, 255, 127, 255, 127});
        cube(85);
        cur_req = "R7 sat low";
        set_cfg('{0, 128, 0, 128, 0, 128, 0, 128, 0, 128, 0, 128});
        cube(85);
        cur_req = "R7 strong chroma";
        set_cfg('{128, 0, 128, 0, 128, 0, 128, 0, 255, 128, 255, 127});
        cube(51);

        // R6: everything away from neutral, random pixels
        cur_req = "R6 mixed";
        set_cfg('{150, 5, 110, 250, 170, 12, 140, 246, 180, 7, 90, 252});
        for (int i = 0; i < 300; i++) send($urandom_range(255), $urandom_range(255), $urandom_range(255));
        idle(8);

        cur_req = "R9 restore";
        set_cfg(neutral);
        cube(85);

        check("R8 all outputs seen", exp_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule